// File: doc/BRIEF.md
# Dual-Queue Conversion Scheduler with Freeze

This block feeds a single converter from two queues of conversion command words. Each queue is armed by its own trigger and then walks a pointer through a 64-entry command table, from a start index to an end index. The pointer wraps modulo 64. For each entry it sends a one-cycle start pulse with the 6-bit command index to the converter. It then waits for the converter's one-cycle done pulse before it moves on. When the last entry of a queue completes, a sticky per-queue completion flag is raised and the queue drops back to idle.

Queue 1 outranks queue 2. A queue 1 trigger that arrives while queue 2 is mid-sequence lets the queue 2 conversion already in flight finish and then parks queue 2 at its next entry. Queue 1 then runs to its end, and queue 2 resumes where it stopped. A debug freeze input stops sequencing cleanly: the conversion in flight is allowed to complete, no new conversion is started, and triggers that arrive during the freeze are dropped. Queue work that was pending or parked before the freeze is kept and carries on after the release.

Top module: `cq_dual_scheduler`

## Requirements
- R1: After synchronous reset, conv_start, cf1, cf2, q1_active, q2_active and conv_busy are all 0.
- R2: A trigger sampled on clock edge k while the block is idle and not frozen sets that queue's active output after edge k. It produces conv_start = 1 with conv_idx equal to that queue's start index after edge k+1.
- R3: At most one conversion is outstanding. conv_start lasts exactly one cycle. After a done pulse that is not for a queue's end entry, the same queue issues its next entry, (index + 1) mod 64, one edge after the done is sampled. With a done latency of L idle cycles, consecutive starts are therefore L+3 cycles apart.
- R4: The done pulse for the entry equal to a queue's end index sets that queue's completion flag (cf1 or cf2) and clears its active output on the same edge. No further conversion is issued for that queue.
- R5: Completion flags stay set until the queue's clear input is sampled high. A completion in the same cycle as a clear leaves the flag set.
- R6: A trigger for a queue that is already active is ignored. Its sequence and pointer are unchanged, even if the start index input has changed.
- R7: When both queues are pending with no conversion outstanding, queue 1 is issued first and runs to its end before queue 2 starts.
- R8: A queue 1 trigger while queue 2 is mid-sequence lets the current queue 2 conversion finish. Queue 1's entries follow, and queue 2 then resumes with its next entry rather than its start.
- R9: While freeze is high, no conversion is started. A conversion in flight when freeze rises still completes and advances its queue. After release, the queue continues with its next entry.
- R10: Triggers on either queue sampled while freeze is high are discarded and never arm a queue.
- R11: A queue 2 trigger that is pending before freeze, and a queue 2 sequence parked behind queue 1 before freeze, are both kept through the freeze. Each runs after queue 1 completes once freeze is released.
- R12: A done pulse with no conversion outstanding has no effect on the flags, the pointers or the active outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze | input | 1 | Debug freeze: hold sequencing, drop triggers |
| q1_trig | input | 1 | Queue 1 trigger, sampled each cycle |
| q1_first | input | 6 | Queue 1 start index |
| q1_last | input | 6 | Queue 1 end index |
| cf1_clr | input | 1 | Clears cf1 |
| q2_trig | input | 1 | Queue 2 trigger, sampled each cycle |
| q2_first | input | 6 | Queue 2 start index |
| q2_last | input | 6 | Queue 2 end index |
| cf2_clr | input | 1 | Clears cf2 |
| conv_done | input | 1 | One-cycle converter completion pulse |
| conv_start | output | 1 | One-cycle conversion request |
| conv_idx | output | 6 | Command index for the request |
| conv_busy | output | 1 | A conversion is outstanding |
| q1_active | output | 1 | Queue 1 armed or running |
| q2_active | output | 1 | Queue 2 armed, running or parked |
| cf1 | output | 1 | Sticky queue 1 completion flag |
| cf2 | output | 1 | Sticky queue 2 completion flag |

## Verification
The active output follows a trigger one edge later, and the first conv_start follows one edge after that. The bench checks both in the half-cycle after each edge. The next start comes one edge after the done is sampled, and with a converter model that answers after L idle cycles, successive starts are L+3 cycles apart. A completion flag rises on the same edge that samples the last done, and a clear takes effect on the edge that samples it. The bench waits for the edge that samples each done and reads the results at the following falling edge. Issued index sequences are logged by the converter model and compared against arithmetic expectations over a sweep of start indices (including wrap at 63), lengths, latencies and queue choice.

// File: rtl/cqs_pkg.sv
package cqs_pkg;

    localparam int unsigned CQS_IDX_W = 6;
    localparam int unsigned CQS_NQ    = 2;

    typedef enum logic {
        SRC_Q1 = 1'b0,
        SRC_Q2 = 1'b1
    } cqs_src_e;

    typedef struct packed {
        logic     busy;
        cqs_src_e owner;
    } cqs_conv_s;

    function automatic cqs_src_e cqs_pick(input logic q1_pending);
        return q1_pending ? SRC_Q1 : SRC_Q2;
    endfunction

endpackage

// File: rtl/cqs_queue_ctl.sv
module cqs_queue_ctl #(
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             freeze,
    input  logic             clr,
    input  logic             adv,
    input  logic [IDX_W-1:0] first_idx,
    input  logic [IDX_W-1:0] last_idx,
    output logic             running,
    output logic [IDX_W-1:0] ptr,
    output logic             done_flag
);

    logic accept;
    logic at_last;

    assign accept  = trig && !freeze && !running;
    assign at_last = (ptr == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            ptr     <= '0;
        end else if (accept) begin
            running <= 1'b1;
            ptr     <= first_idx;
        end else if (adv) begin
            if (at_last) begin
                running <= 1'b0;
            end else begin
                ptr <= ptr + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_flag <= 1'b0;
        end else if (adv && at_last) begin
            done_flag <= 1'b1;
        end else if (clr) begin
            done_flag <= 1'b0;
        end
    end

    // R6: an active queue keeps its pointer unless the converter finishes its entry
    a_r6_run_holds: assert property (@(posedge clk) disable iff (rst)
        running && !adv |=> running && $stable(ptr));

    // R10: a frozen idle queue cannot be armed
    a_r10_frozen_no_arm: assert property (@(posedge clk) disable iff (rst)
        freeze && !running |=> !running);

    // R5: flag is sticky without a clear
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        done_flag && !clr |=> done_flag);

    // R12: the arbiter only advances a queue that is active
    a_r12_adv_needs_run: assert property (@(posedge clk) disable iff (rst)
        adv |-> running);

endmodule

// File: rtl/cqs_arbiter.sv
module cqs_arbiter
    import cqs_pkg::*;
#(
    parameter int unsigned IDX_W = 6,
    parameter int unsigned NQ    = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     freeze,
    input  logic [NQ-1:0]            run,
    input  logic [NQ-1:0][IDX_W-1:0] ptr,
    input  logic                     conv_done,
    output logic                     conv_start,
    output logic [IDX_W-1:0]         conv_idx,
    output logic [NQ-1:0]            adv,
    output logic                     busy
);

    cqs_conv_s cs;
    cqs_src_e  pick;
    logic      issue;
    logic      retire;

    assign pick   = cqs_pick(run[0]);
    assign issue  = !cs.busy && !freeze && (|run);
    assign retire = cs.busy && conv_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs         <= '{busy: 1'b0, owner: SRC_Q1};
            conv_start <= 1'b0;
            conv_idx   <= '0;
        end else begin
            conv_start <= issue;
            if (issue) begin
                cs.busy  <= 1'b1;
                cs.owner <= pick;
                conv_idx <= (pick == SRC_Q1) ? ptr[0] : ptr[1];
            end else if (retire) begin
                cs.busy <= 1'b0;
            end
        end
    end

    assign adv[0] = retire && (cs.owner == SRC_Q1);
    assign adv[1] = retire && (cs.owner == SRC_Q2);
    assign busy   = cs.busy;

    // R3: the request is a single-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R3: no new request while one is outstanding
    a_r3_no_start_busy: assert property (@(posedge clk) disable iff (rst)
        cs.busy && !conv_done |=> !conv_start);

    // R9: freeze blocks the next request
    a_r9_freeze_blocks: assert property (@(posedge clk) disable iff (rst)
        freeze |=> !conv_start);

endmodule

// File: rtl/cq_dual_scheduler.sv
module cq_dual_scheduler
    import cqs_pkg::*;
#(
    parameter int unsigned IDX_W = CQS_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze,
    input  logic             q1_trig,
    input  logic [IDX_W-1:0] q1_first,
    input  logic [IDX_W-1:0] q1_last,
    input  logic             cf1_clr,
    input  logic             q2_trig,
    input  logic [IDX_W-1:0] q2_first,
    input  logic [IDX_W-1:0] q2_last,
    input  logic             cf2_clr,
    input  logic             conv_done,
    output logic             conv_start,
    output logic [IDX_W-1:0] conv_idx,
    output logic             conv_busy,
    output logic             q1_active,
    output logic             q2_active,
    output logic             cf1,
    output logic             cf2
);

    localparam int unsigned NQ = CQS_NQ;

    logic [NQ-1:0]            trig_v;
    logic [NQ-1:0]            clr_v;
    logic [NQ-1:0]            adv_v;
    logic [NQ-1:0]            run_v;
    logic [NQ-1:0]            flag_v;
    logic [NQ-1:0][IDX_W-1:0] first_v;
    logic [NQ-1:0][IDX_W-1:0] last_v;
    logic [NQ-1:0][IDX_W-1:0] ptr_v;

    assign trig_v     = {q2_trig, q1_trig};
    assign clr_v      = {cf2_clr, cf1_clr};
    assign first_v[0] = q1_first;
    assign first_v[1] = q2_first;
    assign last_v[0]  = q1_last;
    assign last_v[1]  = q2_last;

    for (genvar g = 0; g < NQ; g++) begin : g_q
        cqs_queue_ctl #(.IDX_W(IDX_W)) u_q (
            .clk       (clk),
            .rst       (rst),
            .trig      (trig_v[g]),
            .freeze    (freeze),
            .clr       (clr_v[g]),
            .adv       (adv_v[g]),
            .first_idx (first_v[g]),
            .last_idx  (last_v[g]),
            .running   (run_v[g]),
            .ptr       (ptr_v[g]),
            .done_flag (flag_v[g])
        );
    end

    cqs_arbiter #(.IDX_W(IDX_W), .NQ(NQ)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .freeze     (freeze),
        .run        (run_v),
        .ptr        (ptr_v),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .conv_idx   (conv_idx),
        .adv        (adv_v),
        .busy       (conv_busy)
    );

    assign q1_active = run_v[0];
    assign q2_active = run_v[1];
    assign cf1       = flag_v[0];
    assign cf2       = flag_v[1];

    // R4: a completion flag only rises from a done pulse, and the queue goes idle with it
    a_r4_cf1_from_done: assert property (@(posedge clk) disable iff (rst)
        $rose(cf1) |-> $past(conv_done) && !q1_active);
    a_r4_cf2_from_done: assert property (@(posedge clk) disable iff (rst)
        $rose(cf2) |-> $past(conv_done) && !q2_active);

endmodule

// File: tb/sim_cq_dual_scheduler.sv
module sim_cq_dual_scheduler;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       freeze = 1'b0;
    logic       q1_trig = 1'b0, q2_trig = 1'b0;
    logic [5:0] q1_first = '0, q1_last = '0, q2_first = '0, q2_last = '0;
    logic       cf1_clr = 1'b0, cf2_clr = 1'b0;
    logic       conv_done = 1'b0;
    logic       conv_start, conv_busy, q1_active, q2_active, cf1, cf2;
    logic [5:0] conv_idx;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int lat_cfg = 0;
    int nlog = 0;
    int log_idx [64];
    int log_cyc [64];
    int exp_q [64];
    int nexp = 0;
    bit resp_pend = 0;
    int resp_cnt = 0;

    always #4 clk = ~clk;

    cq_dual_scheduler u0 (
        .clk(clk), .rst(rst), .freeze(freeze),
        .q1_trig(q1_trig), .q1_first(q1_first), .q1_last(q1_last), .cf1_clr(cf1_clr),
        .q2_trig(q2_trig), .q2_first(q2_first), .q2_last(q2_last), .cf2_clr(cf2_clr),
        .conv_done(conv_done), .conv_start(conv_start), .conv_idx(conv_idx),
        .conv_busy(conv_busy), .q1_active(q1_active), .q2_active(q2_active),
        .cf1(cf1), .cf2(cf2)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // converter model: answers lat_cfg idle cycles after the request
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (resp_pend) begin
            if (resp_cnt == 0) begin
                conv_done = 1'b1;
                resp_pend = 0;
            end else begin
                resp_cnt = resp_cnt - 1;
            end
        end
        if (conv_start) begin
            if (nlog < 64) begin
                log_idx[nlog] = int'(conv_idx);
                log_cyc[nlog] = cyc;
            end
            nlog = nlog + 1;
            resp_pend = 1;
            resp_cnt = lat_cfg;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic clear_log();
        @(posedge clk);
        nlog = 0;
        nexp = 0;
    endtask

    task automatic push(input int v);
        exp_q[nexp] = v;
        nexp++;
    endtask

    task automatic check_seq(input string tag);
        check(nlog == nexp, {tag, " count"}, nlog, nexp);
        for (int i = 0; i < nexp && i < nlog; i++)
            check(log_idx[i] == exp_q[i], {tag, " index"}, log_idx[i], exp_q[i]);
    endtask

    task automatic pulse_trig(input int q, input int s, input int e);
        @(negedge clk);
        if (q == 1) begin q1_first = 6'(s); q1_last = 6'(e); q1_trig = 1'b1; end
        else        begin q2_first = 6'(s); q2_last = 6'(e); q2_trig = 1'b1; end
        @(negedge clk);
        q1_trig = 1'b0;
        q2_trig = 1'b0;
    endtask

    task automatic wait_log(input int n);
        for (int i = 0; i < 2000 && nlog < n; i++) @(posedge clk);
    endtask

    task automatic wait_flag(input int q);
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk);
            if ((q == 1 && cf1) || (q == 2 && cf2)) break;
        end
        @(negedge clk);
    endtask

    task automatic clear_flags();
        @(negedge clk);
        cf1_clr = 1'b1; cf2_clr = 1'b1;
        @(negedge clk);
        cf1_clr = 1'b0; cf2_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(conv_start == 0 && conv_busy == 0, "R1 converter outputs", conv_start, 0);
        check(cf1 == 0 && cf2 == 0, "R1 flags", {cf2, cf1}, 0);
        check(q1_active == 0 && q2_active == 0, "R1 active", {q2_active, q1_active}, 0);

        // R2 trigger-to-start timing
        clear_log();
        lat_cfg = 1;
        @(negedge clk);
        q1_first = 6'd5; q1_last = 6'd5; q1_trig = 1'b1;
        @(negedge clk);
        q1_trig = 1'b0;
        check(q1_active == 1 && conv_start == 0, "R2 active before start", conv_start, 0);
        @(negedge clk);
        check(conv_start == 1, "R2 start pulse", conv_start, 1);
        check(conv_idx == 6'd5, "R2 start index", conv_idx, 5);
        wait_flag(1);
        check(cf1 == 1 && q1_active == 0, "R4 single entry completes", {q1_active, cf1}, 1);
        push(5);
        check_seq("R2");
        clear_flags();

        // R3 R4 R5 sweep: start, length, latency, queue
        foreach (log_idx[k]) log_idx[k] = 0;
        for (int si = 0; si < 4; si++) begin
            for (int len = 1; len <= 5; len++) begin
                for (int lt = 0; lt < 2; lt++) begin
                    automatic int s = (si == 0) ? 0 : (si == 1) ? 7 : (si == 2) ? 60 : 62;
                    automatic int e = (s + len - 1) % 64;
                    automatic int q = ((si + len + lt) % 2) + 1;
                    clear_log();
                    lat_cfg = lt * 2;
                    for (int i = 0; i < len; i++) push((s + i) % 64);
                    pulse_trig(q, s, e);
                    wait_flag(q);
                    check_seq("R3 sweep");
                    for (int i = 1; i < nlog && i < len; i++)
                        check(log_cyc[i] - log_cyc[i-1] == lat_cfg + 3, "R3 reissue spacing",
                              log_cyc[i] - log_cyc[i-1], lat_cfg + 3);
                    check((q == 1 ? cf1 : cf2) == 1, "R4 flag set", 0, 1);
                    check((q == 1 ? q1_active : q2_active) == 0, "R4 queue idle", 1, 0);
                    idle(3);
                    check((q == 1 ? cf1 : cf2) == 1 && conv_busy == 0, "R5 flag sticky", 0, 1);
                    clear_flags();
                    check(cf1 == 0 && cf2 == 0, "R5 flag cleared", {cf2, cf1}, 0);
                end
            end
        end

        // R5 completion during clear keeps the flag
        clear_log();
        lat_cfg = 2;
        pulse_trig(2, 33, 33);
        @(negedge clk);
        cf2_clr = 1'b1;
        @(posedge clk);
        while (!conv_done) @(posedge clk);
        @(negedge clk);
        check(cf2 == 1, "R5 set wins over clear", cf2, 1);
        @(negedge clk);
        check(cf2 == 0, "R5 clear after set", cf2, 0);
        cf2_clr = 1'b0;

        // R6 retrigger while active ignored
        clear_log();
        lat_cfg = 3;
        pulse_trig(1, 10, 14);
        wait_log(1);
        pulse_trig(1, 40, 14);
        wait_log(3);
        pulse_trig(1, 41, 14);
        wait_flag(1);
        for (int i = 10; i <= 14; i++) push(i);
        check_seq("R6");
        clear_flags();

        // R7 simultaneous triggers: queue 1 first
        clear_log();
        lat_cfg = 1;
        @(negedge clk);
        q1_first = 6'd0; q1_last = 6'd1; q2_first = 6'd20; q2_last = 6'd21;
        q1_trig = 1'b1; q2_trig = 1'b1;
        @(negedge clk);
        q1_trig = 1'b0; q2_trig = 1'b0;
        wait_flag(2);
        push(0); push(1); push(20); push(21);
        check_seq("R7");
        check(cf1 == 1, "R7 queue 1 complete", cf1, 1);
        clear_flags();

        // R8 queue 1 suspends queue 2
        clear_log();
        lat_cfg = 3;
        pulse_trig(2, 30, 33);
        wait_log(2);
        pulse_trig(1, 3, 4);
        wait_flag(1);
        check(q2_active == 1 && cf2 == 0, "R8 queue 2 parked", q2_active, 1);
        wait_flag(2);
        push(30); push(31); push(3); push(4); push(32); push(33);
        check_seq("R8");
        clear_flags();

        // R9 freeze mid-sequence
        clear_log();
        lat_cfg = 4;
        pulse_trig(1, 50, 52);
        wait_log(1);
        @(negedge clk);
        freeze = 1'b1;
        idle(20);
        check(nlog == 1, "R9 no start while frozen", nlog, 1);
        check(q1_active == 1 && conv_busy == 0, "R9 in-flight finished", conv_busy, 0);
        freeze = 1'b0;
        wait_flag(1);
        push(50); push(51); push(52);
        check_seq("R9");
        clear_flags();

        // R10 triggers during freeze dropped
        clear_log();
        @(negedge clk);
        freeze = 1'b1;
        pulse_trig(1, 1, 2);
        pulse_trig(2, 3, 4);
        idle(2);
        freeze = 1'b0;
        idle(15);
        check(nlog == 0, "R10 no conversions", nlog, 0);
        check(q1_active == 0 && q2_active == 0, "R10 queues idle", {q2_active, q1_active}, 0);

        // R11 pending queue 2 trigger kept through freeze
        clear_log();
        lat_cfg = 3;
        pulse_trig(1, 0, 3);
        pulse_trig(2, 10, 11);
        wait_log(2);
        @(negedge clk);
        freeze = 1'b1;
        idle(12);
        check(q2_active == 1, "R11 pending kept", q2_active, 1);
        freeze = 1'b0;
        wait_flag(2);
        push(0); push(1); push(2); push(3); push(10); push(11);
        check_seq("R11 pending");
        clear_flags();

        // R11 parked queue 2 kept through freeze
        clear_log();
        pulse_trig(2, 40, 43);
        wait_log(2);
        pulse_trig(1, 5, 6);
        freeze = 1'b1;
        idle(12);
        check(q1_active == 1 && q2_active == 1, "R11 both held", {q2_active, q1_active}, 3);
        freeze = 1'b0;
        wait_flag(2);
        push(40); push(41); push(5); push(6); push(42); push(43);
        check_seq("R11 parked");
        clear_flags();

        // R12 stray done pulses
        clear_log();
        @(negedge clk);
        #1 conv_done = 1'b1;
        @(negedge clk);
        freeze = 1'b1;
        #1 conv_done = 1'b1;
        @(negedge clk);
        freeze = 1'b0;
        idle(3);
        check(cf1 == 0 && cf2 == 0, "R12 no flag", {cf2, cf1}, 0);
        check(q1_active == 0 && q2_active == 0 && nlog == 0, "R12 no activity", nlog, 0);
        lat_cfg = 0;
        pulse_trig(2, 8, 9);
        wait_flag(2);
        push(8); push(9);
        check_seq("R12 later run");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule